// File: doc/BRIEF.md
# Configuration-Word CRC-6 Readback Generator

This block computes a 6-bit check value over a 24-bit configuration word so a host can confirm what the register holds without changing it. The division uses the generator x^6 + x + 1 (pattern 7'b1000011, 0x43). The word is extended by six zero bits to form a 30-bit dividend. This dividend is divided MSB first. The remainder register starts at zero, and no bit reflection or final inversion is applied. The block only observes the configuration word and never drives it.

The block evaluates the check value in two ways. A bit-serial engine captures the word on an accepted start request and uses one dividend bit per clock. It reports its remainder with a one-cycle done pulse. A combinational divider gives the same remainder for the present input word in the same cycle. A separate combinational checker divides any 30-bit word (data followed by its appended remainder) by the same generator and signals a pass when the residue is zero.

The start request uses a valid/ready handshake. A request is taken on a rising clock edge where `start_valid` and `start_ready` are both high. `start_ready` is low while the engine is busy, so the source must hold `start_valid` until it sees ready. Requests made while busy are never taken. The result side cannot apply back-pressure: the done pulse lasts one cycle and the remainder stays on `crc_serial` until the next result.

Top module: `crc6_readback`

## Requirements
- R1: The remainder equals {word, 6'b0} mod x^6+x+1, computed MSB first with a zero start value, no reflection and no final XOR; word 24'hD70F68 gives 6'h19.
- R2: `crc_par` shows the remainder of the present `cfg_word` combinationally, with no clock edge needed.
- R3: A start is taken on an edge where `start_valid` and `start_ready` are both high. `start_ready` is high when idle and goes low on the cycle after a start is taken.
- R4: `crc_done` goes high exactly 30 clock edges after the edge that took the start. It stays high for exactly one cycle, and `crc_serial` then holds the remainder of the captured word.
- R5: The word is captured on the edge that takes the start. Later changes of `cfg_word` do not change the serial result.
- R6: A `start_valid` pulse while busy is ignored. The run in progress neither restarts nor changes its word, and its done still arrives 30 edges after the original start.
- R7: `crc_serial` holds its value in every cycle in which `crc_done` is low.
- R8: `chk_pass` is 1 exactly when the 30-bit `chk_word` divided by x^6+x+1 leaves a zero residue. 30'h35C3DA19 passes, and any one-bit change of a passing word fails.
- R9: Synchronous reset (`rst` high at an edge) clears `crc_serial` to 0 and `crc_done` to 0, sets `start_ready` to 1, and abandons any run in progress.
- R10: A start held valid during the done cycle is taken on the next edge, so runs can follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 24 | Configuration word that is observed |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Engine idle, can take a start |
| crc_serial | output | 6 | Remainder from the serial engine |
| crc_done | output | 1 | One-cycle pulse when `crc_serial` is updated |
| crc_par | output | 6 | Combinational remainder of `cfg_word` |
| chk_word | input | 30 | Word with its remainder appended, to be verified |
| chk_pass | output | 1 | High when the residue of `chk_word` is zero |

## Verification
The hardest cases to reach are a second start request that arrives while a run is in progress, and an edge where the done cycle and a new start fall together. Both depend on exact cycle alignment at the ports. The stimulus fires a one-cycle `start_valid` pulse with a different word partway through a run, then checks that the original word's remainder still arrives on the original schedule. A separate case holds a request valid across the done cycle and measures that it is taken on the next edge. Captured-word isolation is forced by scrambling `cfg_word` on the cycle after every accepted start.

// File: rtl/crc6_pkg.sv
package crc6_pkg;
  localparam int unsigned DATA_W_DEF = 24;
  localparam int unsigned CRC_W_DEF  = 6;
  // full generator including the implicit top term: x^6 + x + 1
  localparam logic [CRC_W_DEF:0] POLY_DEF = 7'h43;
endpackage

// File: rtl/crc6_bit_step.sv
// One division step: shift one dividend bit into the remainder and
// subtract (XOR) the generator when the outgoing top bit is set.
module crc6_bit_step #(
  parameter int unsigned     CRC_W = crc6_pkg::CRC_W_DEF,
  parameter logic [CRC_W:0]  POLY  = crc6_pkg::POLY_DEF
) (
  input  logic [CRC_W-1:0] rem_in,
  input  logic             bit_in,
  output logic [CRC_W-1:0] rem_out
);
  localparam logic [CRC_W-1:0] TAPS = POLY[CRC_W-1:0];

  always_comb begin
    rem_out = {rem_in[CRC_W-2:0], bit_in};
    if (rem_in[CRC_W-1]) rem_out = rem_out ^ TAPS;
  end
endmodule

// File: rtl/crc6_divider.sv
// Unrolled MSB-first division of an IN_W-bit word, zero initial remainder.
module crc6_divider #(
  parameter int unsigned     IN_W  = 30,
  parameter int unsigned     CRC_W = crc6_pkg::CRC_W_DEF,
  parameter logic [CRC_W:0]  POLY  = crc6_pkg::POLY_DEF
) (
  input  logic [IN_W-1:0]  word,
  output logic [CRC_W-1:0] rem
);
  logic [CRC_W-1:0] stage [IN_W+1];

  assign stage[0] = '0;

  for (genvar i = 0; i < IN_W; i++) begin : g_chain
    crc6_bit_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
      .rem_in (stage[i]),
      .bit_in (word[IN_W-1-i]),
      .rem_out(stage[i+1])
    );
  end

  assign rem = stage[IN_W];
endmodule

// File: rtl/crc6_serial_engine.sv
// Bit-serial divider: captures a word, consumes one dividend bit per clock.
module crc6_serial_engine #(
  parameter int unsigned     DATA_W = crc6_pkg::DATA_W_DEF,
  parameter int unsigned     CRC_W  = crc6_pkg::CRC_W_DEF,
  parameter logic [CRC_W:0]  POLY   = crc6_pkg::POLY_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic [CRC_W-1:0]  result,
  output logic              done
);
  localparam int unsigned TOT_W = DATA_W + CRC_W;
  localparam int unsigned CNT_W = $clog2(TOT_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOT_W - 1);

  logic [TOT_W-1:0] dividend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] rem_next;
  logic             busy_q;
  logic [CRC_W-1:0] result_q;
  logic             done_q;

  crc6_bit_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
    .rem_in (rem_q),
    .bit_in (dividend_q[TOT_W-1]),
    .rem_out(rem_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dividend_q <= '0;
      cnt_q      <= '0;
      rem_q      <= '0;
      busy_q     <= 1'b0;
      result_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load && !busy_q) begin
        dividend_q <= {load_data, {CRC_W{1'b0}}};
        cnt_q      <= '0;
        rem_q      <= '0;
        busy_q     <= 1'b1;
      end else if (busy_q) begin
        dividend_q <= dividend_q << 1;
        rem_q      <= rem_next;
        cnt_q      <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q   <= 1'b0;
          result_q <= rem_next;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign result = result_q;
  assign done   = done_q;

  // R6: a running count advances by one each cycle, never restarts
  assert_count_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R4: the last dividend bit is followed by the done pulse
  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == LAST) |=> (done_q && !busy_q));

  // R4: done lasts a single cycle
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R7: result only moves together with done
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !done_q) |-> $stable(result_q));
endmodule

// File: rtl/crc6_residue_check.sv
// Divides a word that carries its remainder; pass when the residue is zero.
module crc6_residue_check #(
  parameter int unsigned     IN_W  = 30,
  parameter int unsigned     CRC_W = crc6_pkg::CRC_W_DEF,
  parameter logic [CRC_W:0]  POLY  = crc6_pkg::POLY_DEF
) (
  input  logic [IN_W-1:0] word,
  output logic            pass
);
  logic [CRC_W-1:0] residue;

  crc6_divider #(.IN_W(IN_W), .CRC_W(CRC_W), .POLY(POLY)) u_div (
    .word(word),
    .rem (residue)
  );

  assign pass = (residue == '0);
endmodule

// File: rtl/crc6_readback.sv
module crc6_readback #(
  parameter int unsigned     DATA_W = crc6_pkg::DATA_W_DEF,
  parameter int unsigned     CRC_W  = crc6_pkg::CRC_W_DEF,
  parameter logic [CRC_W:0]  POLY   = crc6_pkg::POLY_DEF,
  localparam int unsigned    TOT_W  = DATA_W + CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic              start_valid,
  output logic              start_ready,
  output logic [CRC_W-1:0]  crc_serial,
  output logic              crc_done,
  output logic [CRC_W-1:0]  crc_par,
  input  logic [TOT_W-1:0]  chk_word,
  output logic              chk_pass
);
  logic busy;
  logic accept;

  assign start_ready = !busy;
  assign accept      = start_valid && start_ready;

  crc6_serial_engine #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_serial (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_data(cfg_word),
    .busy     (busy),
    .result   (crc_serial),
    .done     (crc_done)
  );

  crc6_divider #(.IN_W(TOT_W), .CRC_W(CRC_W), .POLY(POLY)) u_par (
    .word({cfg_word, {CRC_W{1'b0}}}),
    .rem (crc_par)
  );

  crc6_residue_check #(.IN_W(TOT_W), .CRC_W(CRC_W), .POLY(POLY)) u_chk (
    .word(chk_word),
    .pass(chk_pass)
  );

  // R3: a taken start closes the handshake on the following cycle
  assert_accept_closes_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !start_ready);

  // R10: ready reopens together with the done pulse
  assert_ready_on_done_R10: assert property (@(posedge clk) disable iff (rst)
    crc_done |-> start_ready);
endmodule

// File: tb/tb_crc6_readback.sv
module tb_crc6_readback;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] cfg_word = '0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [5:0]  crc_serial;
  logic        crc_done;
  logic [5:0]  crc_par;
  logic [29:0] chk_word = '0;
  logic        chk_pass;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  crc6_readback dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .start_valid(start_valid),
    .start_ready(start_ready), .crc_serial(crc_serial), .crc_done(crc_done),
    .crc_par(crc_par), .chk_word(chk_word), .chk_pass(chk_pass)
  );

  localparam logic [23:0] VEC [8] = '{
    24'hD70F68, 24'h000000, 24'hFFFFFF, 24'h800000,
    24'h000001, 24'hA5A5A5, 24'h123456, 24'hC00003
  };

  // long-division reference on the augmented 30-bit value
  function automatic logic [5:0] model_rem(input logic [29:0] v_in);
    logic [29:0] v = v_in;
    for (int i = 29; i >= 6; i--)
      if (v[i]) v = v ^ (30'h43 << (i - 6));
    return v[5:0];
  endfunction

  function automatic logic [5:0] model_crc(input logic [23:0] d);
    return model_rem({d, 6'b0});
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // starts a run with d, scrambles cfg_word afterwards (R5), waits for done
  task automatic run_serial(input logic [23:0] d, output logic [5:0] r, output int lat);
    @(negedge clk);
    cfg_word = d;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    cfg_word = ~d;
    lat = 0;
    while (!crc_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    r = crc_serial;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] r;
    int lat;
    logic [23:0] d;
    logic [5:0] held;

    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "crc_serial reset", 32'(crc_serial), 0);
    check("R9", "crc_done reset", 32'(crc_done), 0);
    check("R9", "start_ready reset", 32'(start_ready), 1);
    rst = 1'b0;

    // R1: stated test vector, literal expectation
    cfg_word = 24'hD70F68;
    #1 check("R1", "par D70F68", 32'(crc_par), 32'h19);

    // R8: stated verification word
    chk_word = 30'h35C3DA19;
    #1 check("R8", "chk 35C3DA19", 32'(chk_pass), 1);

    // table walk: serial, parallel, checker
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfg_word = VEC[k];
      #1 check("R2", "par table", 32'(crc_par), 32'(model_crc(VEC[k])));
      chk_word = {VEC[k], model_crc(VEC[k])};
      #1 check("R8", "chk pass table", 32'(chk_pass), 1);
      chk_word = chk_word ^ (30'h1 << (k * 3));
      #1 check("R8", "chk flip table", 32'(chk_pass), 0);
      run_serial(VEC[k], r, lat);
      check("R1", "serial table", 32'(r), 32'(model_crc(VEC[k])));
      check("R4", "latency table", 32'(lat), 30);
      @(negedge clk);
      check("R4", "done one cycle", 32'(crc_done), 0);
      check("R7", "hold after done", 32'(crc_serial), 32'(r));
    end

    // random words
    for (int k = 0; k < 16; k++) begin
      d = 24'($urandom());
      run_serial(d, r, lat);
      check("R5", "serial random scrambled input", 32'(r), 32'(model_crc(d)));
      cfg_word = d;
      #1 check("R2", "par random", 32'(crc_par), 32'(model_crc(d)));
      chk_word = {d, model_crc(d)};
      #1 check("R8", "chk random", 32'(chk_pass), 1);
    end

    // R7: output holds during a later run until its done
    held = crc_serial;
    @(negedge clk);
    cfg_word = 24'h0F0F0F;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    check("R3", "ready low after accept", 32'(start_ready), 0);
    repeat (10) @(negedge clk);
    check("R7", "hold mid-run", 32'(crc_serial), 32'(held));
    // R6: start pulse while busy, different word
    cfg_word = 24'hFFFF00;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    lat = 11;
    while (!crc_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R6", "latency unchanged by busy start", 32'(lat), 30);
    check("R6", "word unchanged by busy start", 32'(crc_serial), 32'(model_crc(24'h0F0F0F)));
    // R10: start during done cycle taken on next edge
    cfg_word = 24'h5A5A5A;
    start_valid = 1'b1;
    check("R10", "ready in done cycle", 32'(start_ready), 1);
    @(negedge clk);
    start_valid = 1'b0;
    check("R10", "taken right after done", 32'(start_ready), 0);
    lat = 0;
    while (!crc_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R10", "back-to-back latency", 32'(lat), 30);
    check("R10", "back-to-back value", 32'(crc_serial), 32'(model_crc(24'h5A5A5A)));

    // R9: reset abandons a run
    @(negedge clk);
    cfg_word = 24'h777777;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", "crc_serial after mid reset", 32'(crc_serial), 0);
    check("R9", "ready after mid reset", 32'(start_ready), 1);
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (crc_done) lat++;
    end
    check("R9", "no done after abandoned run", 32'(lat), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule